// File: doc/BRIEF.md
# Multi-Byte UART FIFO Access Window

This block sits between a host register bus and the FIFOs of an eight-channel UART. It decodes the host byte address into per-channel pages. It then turns one host access into a batch of one to four FIFO pushes or pops. The serializers and the FIFO storage live outside. Each channel presents its RX occupancy, its four oldest RX bytes with their line-status bytes, and its TX free space. The block answers with pop and push counts on the clock edge that ends the access.

Each channel owns four consecutive 256-byte pages. The first page holds the legacy byte-wide holding register and a separate status byte. The second page is the bulk FIFO window: a write pushes TX bytes and a read pops RX bytes. The third and fourth pages form a read-only window. It returns each received byte packed next to its status byte, so software needs no separate status read. Read data appears on the cycle after the read strobe.

Top module: `uart_fifo_window`

## Requirements
- R1: Address bits [12:10] select the channel and bits [9:8] select the page: 0 is legacy, 1 is the FIFO window, 2 and 3 are the data-plus-status window. Only the addressed channel's pop or push count may be nonzero.
- R2: A FIFO-window read with byte enables 0001, 0011, 0111 or 1111 pops 1, 2, 3 or 4 bytes. Lane 0 (bits [7:0]) carries the oldest byte. The data is on bus_rdata in the cycle after bus_rd, and bus_rdata is zero in any cycle not following a read.
- R3: When a read asks for more bytes than rx_level, only rx_level bytes are popped and the lanes without data read zero.
- R4: A FIFO-window write with a legal enable pattern pushes 1 to 4 bytes. The push data is bus_wdata, with lane i carrying the i-th byte pushed.
- R5: A write that needs more bytes than tx_free pushes only tx_free bytes and sets that channel's tx_ovf bit. The bit stays set until reset.
- R6: A data-plus-status read with enables 0011 pops one byte; with enables 1111 it pops two. Bits [7:0] hold the first byte and [15:8] its status, and bits [23:16] and [31:24] hold the second pair. A returned status has bit 0 forced to 1 as a valid flag. A pair with no data reads as all zero.
- R7: Writes to the data-plus-status window, and reads there with other enable patterns, cause no push, no pop and zero read data.
- R8: The legacy holding register is offset 0x00, lane 0, enables 0001 only. A read pops one byte and a write pushes one byte, with the same free-space and overflow rule as R5.
- R9: The legacy status byte is offset 0x04, lane 1 (bits [15:8]), enables 0010 only. It returns the oldest byte's status with bit 0 set, or zero when the RX FIFO is empty, and pops nothing.
- R10: Reserved offsets and illegal enable patterns read zero and strobe nothing. After reset, bus_rdata and tx_ovf are zero.
- R11: When bus_rd and bus_wr are high together, only the read is performed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_addr | input | 13 | Byte address |
| bus_be | input | 4 | Byte-lane enables |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, one cycle after bus_rd |
| rx_level | input | 8x9 | Per-channel RX FIFO occupancy |
| rx_head_data | input | 8x4x8 | Per-channel four oldest RX bytes, index 0 oldest |
| rx_head_stat | input | 8x4x8 | Line-status byte for each of those RX bytes |
| rx_pop_n | output | 8x3 | Per-channel number of RX bytes to pop this edge |
| tx_free | input | 8x9 | Per-channel TX FIFO free entries |
| tx_push_n | output | 8x3 | Per-channel number of TX bytes to push this edge |
| tx_push_data | output | 32 | TX bytes to push, lane 0 first |
| tx_ovf | output | 8 | Sticky per-channel TX overflow flags |

## Verification
The checker watches every cycle for pops that exceed rx_level, pushes that exceed tx_free, and strobes on more than one channel. It also checks that strobes are quiet without an access, that writes are suppressed during reads, that overflow flags stay sticky, and that read data is zero after non-read cycles. Byte ordering, lane zeroing on shortage, status packing and the bit-0 valid flag are shown only by the bench's address and enable scenarios. So are the legacy offsets and the silence of reserved addresses.

// File: rtl/uart_fifo_window_pkg.sv
package uart_fifo_window_pkg;

    typedef enum logic [2:0] {
        ACC_NONE  = 3'd0,
        ACC_FIFO  = 3'd1,
        ACC_PAIR  = 3'd2,
        ACC_HOLD  = 3'd3,
        ACC_LSTAT = 3'd4
    } acc_kind_e;

    // Enable patterns starting at lane 0 map to a byte count; others give 0.
    function automatic logic [2:0] lanes_from_be(input logic [3:0] be);
        case (be)
            4'b0001: return 3'd1;
            4'b0011: return 3'd2;
            4'b0111: return 3'd3;
            4'b1111: return 3'd4;
            default: return 3'd0;
        endcase
    endfunction

endpackage

// File: rtl/ufw_decode.sv
module ufw_decode
    import uart_fifo_window_pkg::*;
#(
    parameter int NUM_CH = 8,
    parameter int CH_W   = 3,
    parameter int ADDR_W = 13
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [3:0]        be,
    output acc_kind_e         kind,
    output logic [CH_W-1:0]   chan,
    output logic [2:0]        nbytes
);
    logic [1:0] page;
    logic [5:0] word;

    assign page = addr[9:8];
    assign word = addr[7:2];
    assign chan = addr[ADDR_W-1:10];

    always_comb begin
        kind   = ACC_NONE;
        nbytes = 3'd0;
        if (int'(chan) < NUM_CH) begin
            case (page)
                2'd0: begin
                    if (word == 6'd0 && be == 4'b0001) begin
                        kind   = ACC_HOLD;
                        nbytes = 3'd1;
                    end else if (word == 6'd1 && be == 4'b0010) begin
                        kind = ACC_LSTAT;
                    end
                end
                2'd1: begin
                    nbytes = lanes_from_be(be);
                    if (nbytes != 3'd0) kind = ACC_FIFO;
                end
                default: begin
                    if (be == 4'b0011) begin
                        kind   = ACC_PAIR;
                        nbytes = 3'd1;
                    end else if (be == 4'b1111) begin
                        kind   = ACC_PAIR;
                        nbytes = 3'd2;
                    end
                end
            endcase
        end
    end
endmodule

// File: rtl/ufw_rx_pack.sv
module ufw_rx_pack
    import uart_fifo_window_pkg::*;
#(
    parameter int LVL_W = 9
) (
    input  acc_kind_e        kind,
    input  logic [2:0]       nbytes,
    input  logic [LVL_W-1:0] level,
    input  logic [3:0][7:0]  head_data,
    input  logic [3:0][7:0]  head_stat,
    output logic [31:0]      word,
    output logic [2:0]       take
);
    logic [2:0] avail;

    assign avail = (level >= LVL_W'(nbytes)) ? nbytes : level[2:0];

    always_comb begin
        word = 32'd0;
        take = 3'd0;
        case (kind)
            ACC_FIFO, ACC_HOLD: begin
                take = avail;
                for (int i = 0; i < 4; i++) begin
                    if (i < int'(avail)) word[8*i +: 8] = head_data[i];
                end
            end
            ACC_PAIR: begin
                take = avail;
                for (int p = 0; p < 2; p++) begin
                    if (p < int'(avail)) begin
                        word[16*p +: 8]     = head_data[p];
                        word[16*p + 8 +: 8] = head_stat[p] | 8'h01;
                    end
                end
            end
            ACC_LSTAT: begin
                if (level != '0) word[15:8] = head_stat[0] | 8'h01;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/ufw_tx_gate.sv
module ufw_tx_gate #(
    parameter int LVL_W = 9
) (
    input  logic [2:0]       nbytes,
    input  logic [LVL_W-1:0] free,
    output logic [2:0]       push,
    output logic             over
);
    assign over = (LVL_W'(nbytes) > free);
    assign push = over ? free[2:0] : nbytes;
endmodule

// File: rtl/uart_fifo_window.sv
module uart_fifo_window
    import uart_fifo_window_pkg::*;
#(
    parameter int NUM_CH = 8,
    parameter int LVL_W  = 9,
    localparam int CH_W   = $clog2(NUM_CH),
    localparam int ADDR_W = CH_W + 10
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          bus_rd,
    input  logic                          bus_wr,
    input  logic [ADDR_W-1:0]             bus_addr,
    input  logic [3:0]                    bus_be,
    input  logic [31:0]                   bus_wdata,
    output logic [31:0]                   bus_rdata,
    input  logic [NUM_CH-1:0][LVL_W-1:0]  rx_level,
    input  logic [NUM_CH-1:0][3:0][7:0]   rx_head_data,
    input  logic [NUM_CH-1:0][3:0][7:0]   rx_head_stat,
    output logic [NUM_CH-1:0][2:0]        rx_pop_n,
    input  logic [NUM_CH-1:0][LVL_W-1:0]  tx_free,
    output logic [NUM_CH-1:0][2:0]        tx_push_n,
    output logic [31:0]                   tx_push_data,
    output logic [NUM_CH-1:0]             tx_ovf
);
    typedef struct packed {
        logic [31:0]       rdata;
        logic [NUM_CH-1:0] ovf;
    } state_t;

    state_t st_d, st_q;

    acc_kind_e       kind;
    logic [CH_W-1:0] chan;
    logic [2:0]      nbytes;
    logic [31:0]     rx_word;
    logic [2:0]      rx_take;
    logic [2:0]      tx_push;
    logic            tx_over;
    logic            is_rx_kind;
    logic            is_tx_kind;

    ufw_decode #(
        .NUM_CH (NUM_CH),
        .CH_W   (CH_W),
        .ADDR_W (ADDR_W)
    ) decode_i (
        .addr   (bus_addr),
        .be     (bus_be),
        .kind   (kind),
        .chan   (chan),
        .nbytes (nbytes)
    );

    ufw_rx_pack #(
        .LVL_W (LVL_W)
    ) rx_pack_i (
        .kind      (kind),
        .nbytes    (nbytes),
        .level     (rx_level[chan]),
        .head_data (rx_head_data[chan]),
        .head_stat (rx_head_stat[chan]),
        .word      (rx_word),
        .take      (rx_take)
    );

    ufw_tx_gate #(
        .LVL_W (LVL_W)
    ) tx_gate_i (
        .nbytes (nbytes),
        .free   (tx_free[chan]),
        .push   (tx_push),
        .over   (tx_over)
    );

    assign is_rx_kind = (kind == ACC_FIFO) || (kind == ACC_PAIR) ||
                        (kind == ACC_HOLD) || (kind == ACC_LSTAT);
    assign is_tx_kind = (kind == ACC_FIFO) || (kind == ACC_HOLD);

    always_comb begin
        st_d       = st_q;
        st_d.rdata = 32'd0;
        rx_pop_n   = '0;
        tx_push_n  = '0;
        if (bus_rd) begin
            if (is_rx_kind) begin
                st_d.rdata     = rx_word;
                rx_pop_n[chan] = rx_take;
            end
        end else if (bus_wr && is_tx_kind) begin
            tx_push_n[chan] = tx_push;
            if (tx_over) st_d.ovf[chan] = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign bus_rdata    = st_q.rdata;
    assign tx_ovf       = st_q.ovf;
    assign tx_push_data = bus_wdata;

endmodule

// File: rtl/uart_fifo_window_chk.sv
module uart_fifo_window_chk #(
    parameter int NUM_CH = 8,
    parameter int LVL_W  = 9
) (
    input logic                          clk,
    input logic                          rst_n,
    input logic                          bus_rd,
    input logic                          bus_wr,
    input logic [31:0]                   bus_rdata,
    input logic [NUM_CH-1:0][LVL_W-1:0]  rx_level,
    input logic [NUM_CH-1:0][2:0]        rx_pop_n,
    input logic [NUM_CH-1:0][LVL_W-1:0]  tx_free,
    input logic [NUM_CH-1:0][2:0]        tx_push_n,
    input logic [NUM_CH-1:0]             tx_ovf
);
    logic [NUM_CH-1:0] active;
    logic              any_push;

    always_comb begin
        for (int c = 0; c < NUM_CH; c++) begin
            active[c] = (rx_pop_n[c] != 3'd0) || (tx_push_n[c] != 3'd0);
        end
        any_push = (tx_push_n != '0);
    end

    assert_one_channel_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(active));

    assert_idle_rdata_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd |=> bus_rdata == 32'd0);

    assert_quiet_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_rd && !bus_wr) |-> active == '0);

    assert_read_wins_R11: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rd |-> !any_push);

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        assert_pop_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
            LVL_W'(rx_pop_n[c]) <= rx_level[c]);

        assert_push_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
            LVL_W'(tx_push_n[c]) <= tx_free[c]);

        assert_ovf_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
            tx_ovf[c] |=> tx_ovf[c]);
    end
endmodule

bind uart_fifo_window uart_fifo_window_chk #(
    .NUM_CH (NUM_CH),
    .LVL_W  (LVL_W)
) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_rd    (bus_rd),
    .bus_wr    (bus_wr),
    .bus_rdata (bus_rdata),
    .rx_level  (rx_level),
    .rx_pop_n  (rx_pop_n),
    .tx_free   (tx_free),
    .tx_push_n (tx_push_n),
    .tx_ovf    (tx_ovf)
);

// File: tb/uart_fifo_window_tb_top.sv
`timescale 1ns/1ps
module uart_fifo_window_tb_top;
    localparam int NCH = 8;
    localparam int LW  = 9;

    logic                      clk = 1'b0;
    logic                      rst_n = 1'b0;
    logic                      bus_rd = 1'b0;
    logic                      bus_wr = 1'b0;
    logic [12:0]               bus_addr = '0;
    logic [3:0]                bus_be = '0;
    logic [31:0]               bus_wdata = '0;
    logic [31:0]               bus_rdata;
    logic [NCH-1:0][LW-1:0]    rx_level = '0;
    logic [NCH-1:0][3:0][7:0]  rx_head_data;
    logic [NCH-1:0][3:0][7:0]  rx_head_stat;
    logic [NCH-1:0][2:0]       rx_pop_n;
    logic [NCH-1:0][LW-1:0]    tx_free = '0;
    logic [NCH-1:0][2:0]       tx_push_n;
    logic [31:0]               tx_push_data;
    logic [NCH-1:0]            tx_ovf;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    uart_fifo_window dut_i (
        .clk(clk), .rst_n(rst_n), .bus_rd(bus_rd), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_be(bus_be), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .rx_level(rx_level), .rx_head_data(rx_head_data),
        .rx_head_stat(rx_head_stat), .rx_pop_n(rx_pop_n), .tx_free(tx_free),
        .tx_push_n(tx_push_n), .tx_push_data(tx_push_data), .tx_ovf(tx_ovf)
    );

    // Head byte i of channel c is 0x10*c + i + 1; its status is 0x20 + 2*i.
    initial begin
        for (int c = 0; c < NCH; c++) begin
            for (int i = 0; i < 4; i++) begin
                rx_head_data[c][i] = 8'(8'h10 * c + i + 1);
                rx_head_stat[c][i] = 8'(8'h20 + 2 * i);
            end
        end
    end

    typedef struct packed {
        logic        rd;
        logic        wr;
        logic [12:0] addr;
        logic [3:0]  be;
        logic [31:0] wdata;
        logic [8:0]  lvl;
        logic [8:0]  free;
        logic [31:0] exp_rd;
        logic [2:0]  exp_n;
        logic [2:0]  exp_ch;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 17;
    localparam vec_t VECS [NV] = '{
        // R2: full-width read, lane 0 oldest
        '{1'b1, 1'b0, 13'h0100, 4'hF, 32'h0, 9'd10, 9'd0, 32'h04030201, 3'd4, 3'd0, 4'd2},
        // R2: byte read on channel 2
        '{1'b1, 1'b0, 13'h0900, 4'h1, 32'h0, 9'd10, 9'd0, 32'h00000021, 3'd1, 3'd2, 4'd2},
        // R3: three asked, two present
        '{1'b1, 1'b0, 13'h1D00, 4'h7, 32'h0, 9'd2, 9'd0, 32'h00007271, 3'd2, 3'd7, 4'd3},
        // R3: empty FIFO
        '{1'b1, 1'b0, 13'h0D00, 4'hF, 32'h0, 9'd0, 9'd0, 32'h00000000, 3'd0, 3'd3, 4'd3},
        // R6: two data/status pairs
        '{1'b1, 1'b0, 13'h0600, 4'hF, 32'h0, 9'd5, 9'd0, 32'h23122111, 3'd2, 3'd1, 4'd6},
        // R6: one pair, upper page of the window
        '{1'b1, 1'b0, 13'h1304, 4'h3, 32'h0, 9'd5, 9'd0, 32'h00002141, 3'd1, 3'd4, 4'd6},
        // R6: second pair missing reads zero
        '{1'b1, 1'b0, 13'h1600, 4'hF, 32'h0, 9'd1, 9'd0, 32'h00002151, 3'd1, 3'd5, 4'd6},
        // R7: byte-wide read of the pair window ignored
        '{1'b1, 1'b0, 13'h0200, 4'h1, 32'h0, 9'd5, 9'd0, 32'h00000000, 3'd0, 3'd0, 4'd7},
        // R10: non-contiguous enables ignored
        '{1'b1, 1'b0, 13'h0100, 4'h5, 32'h0, 9'd5, 9'd0, 32'h00000000, 3'd0, 3'd0, 4'd10},
        // R4: four-byte push
        '{1'b0, 1'b1, 13'h1900, 4'hF, 32'hDDCCBBAA, 9'd0, 9'd100, 32'h0, 3'd4, 3'd6, 4'd4},
        // R5: two asked, one free
        '{1'b0, 1'b1, 13'h0500, 4'h3, 32'h00005A5B, 9'd0, 9'd1, 32'h0, 3'd1, 3'd1, 4'd5},
        // R7: write to the pair window ignored
        '{1'b0, 1'b1, 13'h0A00, 4'hF, 32'h11223344, 9'd0, 9'd50, 32'h0, 3'd0, 3'd2, 4'd7},
        // R8: legacy holding read
        '{1'b1, 1'b0, 13'h0800, 4'h1, 32'h0, 9'd3, 9'd0, 32'h00000021, 3'd1, 3'd2, 4'd8},
        // R9: legacy status byte, no pop
        '{1'b1, 1'b0, 13'h0804, 4'h2, 32'h0, 9'd3, 9'd0, 32'h00002100, 3'd0, 3'd2, 4'd9},
        // R8: wide access to holding register ignored
        '{1'b1, 1'b0, 13'h0800, 4'h3, 32'h0, 9'd3, 9'd0, 32'h00000000, 3'd0, 3'd2, 4'd8},
        // R8: legacy holding write
        '{1'b0, 1'b1, 13'h0C00, 4'h1, 32'h00000055, 9'd0, 9'd5, 32'h0, 3'd1, 3'd3, 4'd8},
        // R10: reserved legacy offset
        '{1'b1, 1'b0, 13'h0808, 4'hF, 32'h0, 9'd3, 9'd0, 32'h00000000, 3'd0, 3'd2, 4'd10}
    };

    task automatic chk(input bit ok, input int req, input logic [31:0] act,
                       input logic [31:0] exp, input string what);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL R%0d %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic idle();
        bus_rd = 1'b0;
        bus_wr = 1'b0;
        bus_be = 4'h0;
        bus_addr = '0;
    endtask

    // Drives one access at a falling edge, checks strobes, then read data.
    task automatic access(input logic rd, input logic wr, input logic [12:0] addr,
                          input logic [3:0] be, input logic [31:0] wd,
                          input logic [8:0] lvl, input logic [8:0] fr,
                          input logic [31:0] exp_rd, input logic [2:0] exp_n,
                          input logic [2:0] exp_ch, input int req);
        @(negedge clk);
        bus_rd = rd; bus_wr = wr; bus_addr = addr; bus_be = be; bus_wdata = wd;
        for (int c = 0; c < NCH; c++) begin
            rx_level[c] = lvl;
            tx_free[c]  = fr;
        end
        #1;
        for (int c = 0; c < NCH; c++) begin
            logic [2:0] ep, eu;
            ep = (rd && c == int'(exp_ch)) ? exp_n : 3'd0;
            eu = (!rd && wr && c == int'(exp_ch)) ? exp_n : 3'd0;
            chk(rx_pop_n[c] == ep, req, 32'(rx_pop_n[c]), 32'(ep), $sformatf("pop ch%0d", c));
            chk(tx_push_n[c] == eu, req, 32'(tx_push_n[c]), 32'(eu), $sformatf("push ch%0d", c));
        end
        if (!rd && wr && exp_n != 3'd0)
            chk(tx_push_data == wd, req, tx_push_data, wd, "push data");
        @(posedge clk);
        #1;
        chk(bus_rdata == exp_rd, req, bus_rdata, exp_rd, "rdata");
        idle();
    endtask

    initial begin
        #2_000_000;
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        // R10: reset state
        chk(bus_rdata == 32'd0, 10, bus_rdata, 32'd0, "reset rdata");
        chk(tx_ovf == '0, 10, 32'(tx_ovf), 32'd0, "reset ovf");
        @(negedge clk);
        rst_n = 1'b1;

        for (int v = 0; v < NV; v++) begin
            access(VECS[v].rd, VECS[v].wr, VECS[v].addr, VECS[v].be, VECS[v].wdata,
                   VECS[v].lvl, VECS[v].free, VECS[v].exp_rd, VECS[v].exp_n,
                   VECS[v].exp_ch, int'(VECS[v].req));
        end

        // R5: only channel 1 overflowed in the table
        chk(tx_ovf == 8'h02, 5, 32'(tx_ovf), 32'h02, "ovf after table");
        // R5: a fitting write leaves the flag set
        access(1'b0, 1'b1, 13'h0500, 4'h1, 32'h77, 9'd0, 9'd9, 32'h0, 3'd1, 3'd1, 5);
        chk(tx_ovf == 8'h02, 5, 32'(tx_ovf), 32'h02, "ovf sticky");
        // R8: legacy write with no room overflows channel 3
        access(1'b0, 1'b1, 13'h0C00, 4'h1, 32'h66, 9'd0, 9'd0, 32'h0, 3'd0, 3'd3, 8);
        chk(tx_ovf == 8'h0A, 8, 32'(tx_ovf), 32'h0A, "legacy ovf");
        // R11: read and write together: read only
        access(1'b1, 1'b1, 13'h0100, 4'hF, 32'h99999999, 9'd10, 9'd10, 32'h04030201, 3'd4, 3'd0, 11);
        // R1: top word of a FIFO window still decodes
        access(1'b1, 1'b0, 13'h01FC, 4'h1, 32'h0, 9'd4, 9'd0, 32'h00000001, 3'd1, 3'd0, 1);
        // R2: idle cycle returns zero
        @(negedge clk);
        @(posedge clk);
        #1;
        chk(bus_rdata == 32'd0, 2, bus_rdata, 32'd0, "idle rdata");

        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule